// File: doc/BRIEF.md
# Zero-overhead hardware loop controller

The block sits beside the instruction fetch address logic and repeats a loop body without any branch instruction and without flushing the pipeline. Software programs a loop-start address, a loop-end address and an iteration count through a small write port. Each cycle the fetch unit presents the address it is fetching now. The controller returns the address to fetch next. That address is normally the current one plus one 8-byte fetch group. When an armed loop reaches its last group and iterations remain, the controller returns the loop start instead.

The loop-end address names the last 8-byte fetch group of the body, and both addresses are stored with their low three bits cleared. The iteration counter holds the number of passes still to run, counting the current one. It is visible on an output port, and the loop is active whenever it is non-zero. A taken branch from the execute stage and a stalled fetch both take precedence over the loop redirect.

Top module: `zol_ctrl`

## Requirements
- R1: After synchronous reset, `loop_count` is 0 and `loop_active` is 0.
- R2: A write with `cfg_we`=1 stores `cfg_wdata` in the register picked by `cfg_sel`: 0 = loop start, 1 = loop end, 2 = iteration count, 3 = no register. Both addresses are stored with bits [2:0] forced to zero.
- R3: Writing a non-zero count arms the loop. `loop_count` reads back the value written on the next cycle, and `loop_active` equals (`loop_count` != 0). Writing 0 disarms the loop.
- R4: With `fetch_go`=1, no taken branch, and no loop match, `next_pc` = `fetch_pc` + 8.
- R5: When the loop is active, `fetch_go`=1, no branch is taken, `fetch_pc` equals the loop end, and `loop_count` > 1, then `next_pc` equals the loop start in that same cycle. `loop_count` drops by exactly one on the next cycle. A loop armed with count N therefore produces N-1 redirects, and each of them costs no extra cycle.
- R6: On the same match with `loop_count` = 1, `next_pc` = `fetch_pc` + 8. On the next cycle `loop_count` is 0 and `loop_active` is 0.
- R7: When `br_taken`=1, `next_pc` = `br_target`, and the counter is unchanged even if `fetch_pc` equals the loop end.
- R8: When `fetch_go`=0 and `br_taken`=0, `next_pc` = `fetch_pc`, and the counter is unchanged.
- R9: When the loop is inactive, a `fetch_pc` equal to the stored loop end has no effect: `next_pc` = `fetch_pc` + 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 start, 1 end, 2 count, 3 none |
| cfg_wdata | input | 32 | Write data (address or count in low bits) |
| fetch_pc | input | 32 | Address being fetched this cycle |
| fetch_go | input | 1 | Fetch advances this cycle |
| br_taken | input | 1 | Taken branch from execute |
| br_target | input | 32 | Target of the taken branch |
| next_pc | output | 32 | Address to fetch next |
| loop_active | output | 1 | Loop armed, iterations remain |
| loop_count | output | 16 | Remaining iteration count |

## Verification
A counter that steps wrongly shows up on `loop_count` one cycle after the end-group fetch. It then also shows one iteration later in `next_pc`, as a redirect too many or too few before the fall-through. A bad comparison or a wrong priority shows up on `next_pc` in the same cycle as the fetch that triggers it. The bench therefore steps through the exact fetch address sequence cycle by cycle and compares both outputs at every step. Address alignment errors show up the first time the loop start is returned.

// File: rtl/zol_pkg.sv
package zol_pkg;
    localparam int unsigned GRAN_BYTES = 8;

    typedef enum logic [1:0] {
        SEL_START = 2'd0,
        SEL_END   = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        NXT_SEQ    = 2'd0,
        NXT_LOOP   = 2'd1,
        NXT_BRANCH = 2'd2,
        NXT_HOLD   = 2'd3
    } nxt_src_e;

    typedef struct packed {
        logic     hit;
        logic     last;
        nxt_src_e src;
    } match_t;
endpackage

// File: rtl/zol_regs.sv
module zol_regs
    import zol_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  cfg_sel_e      cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          dec,
    output logic [AW-1:0] lp_start,
    output logic [AW-1:0] lp_end,
    output logic [CW-1:0] cnt
);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(GRAN_BYTES - 1);

    logic cnt_wr;
    assign cnt_wr = cfg_we && (cfg_sel == SEL_COUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            lp_start <= '0;
            lp_end   <= '0;
        end else if (cfg_we) begin
            if (cfg_sel == SEL_START) lp_start <= cfg_wdata & ALIGN_MASK;
            if (cfg_sel == SEL_END)   lp_end   <= cfg_wdata & ALIGN_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                    cnt <= '0;
        else if (cnt_wr)            cnt <= cfg_wdata[CW-1:0];
        else if (dec && cnt != '0)  cnt <= cnt - CW'(1);
    end

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/zol_match.sv
module zol_match
    import zol_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          fetch_go,
    input  logic [AW-1:0] fetch_pc,
    input  logic          br_taken,
    input  logic [AW-1:0] br_target,
    input  logic [AW-1:0] lp_start,
    input  logic [AW-1:0] lp_end,
    input  logic [CW-1:0] cnt,
    output match_t        m,
    output logic [AW-1:0] next_pc
);
    logic armed;
    assign armed = (cnt != '0);

    always_comb begin
        m.hit  = armed && fetch_go && !br_taken && (fetch_pc == lp_end);
        m.last = m.hit && (cnt == CW'(1));
        if (br_taken)             m.src = NXT_BRANCH;
        else if (!fetch_go)       m.src = NXT_HOLD;
        else if (m.hit && !m.last) m.src = NXT_LOOP;
        else                      m.src = NXT_SEQ;
    end

    always_comb begin
        unique case (m.src)
            NXT_BRANCH: next_pc = br_target;
            NXT_HOLD:   next_pc = fetch_pc;
            NXT_LOOP:   next_pc = lp_start;
            default:    next_pc = fetch_pc + AW'(GRAN_BYTES);
        endcase
    end
endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl
    import zol_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic [AW-1:0] fetch_pc,
    input  logic          fetch_go,
    input  logic          br_taken,
    input  logic [AW-1:0] br_target,
    output logic [AW-1:0] next_pc,
    output logic          loop_active,
    output logic [CW-1:0] loop_count
);
    logic [AW-1:0] lp_start, lp_end;
    match_t        m;
    logic          cnt_wr;

    assign cnt_wr = cfg_we && (cfg_sel == 2'(SEL_COUNT));

    zol_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel_e'(cfg_sel)),
        .cfg_wdata(cfg_wdata),
        .dec      (m.hit),
        .lp_start (lp_start),
        .lp_end   (lp_end),
        .cnt      (loop_count)
    );

    zol_match #(.AW(AW), .CW(CW)) u_match (
        .fetch_go (fetch_go),
        .fetch_pc (fetch_pc),
        .br_taken (br_taken),
        .br_target(br_target),
        .lp_start (lp_start),
        .lp_end   (lp_end),
        .cnt      (loop_count),
        .m        (m),
        .next_pc  (next_pc)
    );

    assign loop_active = (loop_count != '0);

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (loop_count == '0 && !loop_active));
    // R5
    loop_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        (m.hit && !m.last) |-> (next_pc == lp_start && next_pc != fetch_pc + AW'(GRAN_BYTES) || lp_start == fetch_pc + AW'(GRAN_BYTES)));
    // R6
    last_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (m.last && !cnt_wr) |=> !loop_active);
    // R7
    br_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (br_taken && !cnt_wr) |=> $stable(loop_count));
    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!fetch_go && !cnt_wr) |=> $stable(loop_count));
endmodule

// File: tb/sim_zol_ctrl.sv
module sim_zol_ctrl;
    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd3;
    logic [AW-1:0] cfg_wdata = '0;
    logic [AW-1:0] fetch_pc = '0;
    logic          fetch_go = 1'b1;
    logic          br_taken = 1'b0;
    logic [AW-1:0] br_target = '0;
    logic [AW-1:0] next_pc;
    logic          loop_active;
    logic [CW-1:0] loop_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    zol_ctrl #(.AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .fetch_pc(fetch_pc), .fetch_go(fetch_go),
        .br_taken(br_taken), .br_target(br_target), .next_pc(next_pc),
        .loop_active(loop_active), .loop_count(loop_count)
    );

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = 2'd3;
    endtask

    // R2 R3 R4 R5 R6: exact fetch sequence for n passes
    task automatic run_loop(input logic [AW-1:0] s, input logic [AW-1:0] e, input int n);
        logic [AW-1:0] sa, ea, pc, exp;
        int cnt, redirs, steps;
        sa = s & ~32'h7; ea = e & ~32'h7;
        wr(2'd0, s); wr(2'd1, e); wr(2'd2, AW'(n));
        #1;
        chk("R3 count readback", AW'(loop_count), AW'(n));
        chk("R3 active after arm", AW'(loop_active), AW'(n != 0));
        pc = sa; cnt = n; redirs = 0; steps = 0;
        while (cnt > 0 && steps < 1000) begin
            steps++;
            if (pc == ea && cnt > 1) begin exp = sa; cnt--; redirs++; end
            else if (pc == ea) begin exp = pc + 8; cnt = 0; end
            else exp = pc + 8;
            fetch_pc = pc; #1;
            chk(pc == ea ? (cnt > 0 ? "R5 redirect to start" : "R6 fall through") : "R4 sequential", next_pc, exp);
            @(negedge clk);
            chk("R5 count step", AW'(loop_count), AW'(cnt));
            pc = exp;
        end
        chk("R5 redirect total", AW'(redirs), AW'(n - 1));
        chk("R6 active cleared", AW'(loop_active), 0);
        // R9: inactive, end address no effect
        fetch_pc = ea; #1;
        chk("R9 inactive end no effect", next_pc, ea + 8);
        @(negedge clk);
        chk("R9 count stays zero", AW'(loop_count), 0);
    endtask

    task automatic t_reset;
        #1;
        chk("R1 count at reset", AW'(loop_count), 0);
        chk("R1 active at reset", AW'(loop_active), 0);
        fetch_pc = 32'h40; #1;
        chk("R4 seq after reset", next_pc, 32'h48);
    endtask

    task automatic t_zero_count;
        wr(2'd0, 32'h300); wr(2'd1, 32'h308); wr(2'd2, 32'd4);
        #1 chk("R3 armed", AW'(loop_active), 1);
        wr(2'd2, 32'd0);
        #1 chk("R3 zero disarms", AW'(loop_active), 0);
        fetch_pc = 32'h308; #1;
        chk("R9 disarmed end", next_pc, 32'h310);
        // sel 3 writes nothing
        wr(2'd3, 32'd5);
        #1 chk("R2 sel none no effect", AW'(loop_count), 0);
    endtask

    task automatic t_branch_stall;
        wr(2'd0, 32'h400); wr(2'd1, 32'h410); wr(2'd2, 32'd3);
        @(negedge clk);
        fetch_pc = 32'h410; br_taken = 1'b1; br_target = 32'h900; #1;
        chk("R7 branch wins", next_pc, 32'h900);
        @(negedge clk);
        br_taken = 1'b0;
        chk("R7 count unchanged", AW'(loop_count), 3);
        fetch_go = 1'b0; #1;
        chk("R8 stall holds pc", next_pc, 32'h410);
        @(negedge clk);
        chk("R8 count unchanged", AW'(loop_count), 3);
        fetch_go = 1'b1; #1;
        chk("R5 redirect after stall", next_pc, 32'h400);
        @(negedge clk);
        chk("R5 count after redirect", AW'(loop_count), 2);
        wr(2'd2, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        run_loop(32'h100, 32'h110, 3);
        run_loop(32'h180, 32'h188, 1);
        run_loop(32'h205, 32'h20f, 2);   // R2 alignment
        run_loop(32'h1000, 32'h1000, 5); // single-group body
        t_zero_count();
        t_branch_stall();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule